// File: doc/BRIEF.md
# Programmable Routing Switch Box

This block is one programmable interconnect point of a routing fabric. Wire segments arrive from the north, east, south and west sides, each side with `TRK` tracks, and every track segment has a fixed direction: an input and an output per side per track. A configuration register decides which inputs reach which outputs. Each output side is served by one kind of switch, and extra compound crossings carry one or two nets across a single point. Every switch is a logical selection that one or more configuration bits control; no electrical or bidirectional drive is modelled.

The configuration is a single serial scan chain. While `cfg_en` is high the chain shifts one bit per clock, most significant bit first, and every routing output is forced to 0 so that no partial pattern reaches the fabric. Once `cfg_en` drops, the routing is purely combinational from the segment inputs and the stored bits. Per track `t` the bits start at index `7*t`; the compound crossings follow from index `7*TRK`, six bits each.

Top module: `route_switch_box`

## Requirements
- R1: After reset every configuration bit is 0, so every routing output and `mux_err` read 0 whatever the inputs.
- R2: With `cfg_en` high, each rising clock edge shifts `cfg_din` into bit 0 of the chain and moves every bit up one place; `cfg_dout` always shows the top bit (index `7*TRK+6*NCC-1`), so a pattern sent most significant bit first is read back in the same order.
- R3: While `cfg_en` is high, all routing outputs and `mux_err` are 0.
- R4: Breakpoint: `e_out[t]` equals `w_in[t]` when bit `7*t` is 1 and is 0 when it is 0.
- R5: Cross-point: `s_out[t]` equals `e_in[t]` (the eastern segment turning south) when bit `7*t+1` is 1, else 0.
- R6: Decoded multiplexer: the 2-bit code in bits `7*t+3:7*t+2` drives `n_out[t]` with 0 for code 0, `s_in[t]` for code 1, `w_in[t]` for code 2 and `e_in[t]` for code 3.
- R7: Non-decoded multiplexer: enable bits `7*t+4`, `7*t+5`, `7*t+6` pass `e_in[t]`, `n_in[t]`, `s_in[t]` respectively to `w_out[t]`; with no enable set, `w_out[t]` is 0.
- R8: When more than one enable of a non-decoded multiplexer is set, `mux_err` is 1 and the set enable with the lowest bit index wins; with every such multiplexer at most one-hot, `mux_err` is 0.
- R9: Compound crossing `c` has ends at `cx_in/cx_out[4*c+k]`, k = 0 north, 1 east, 2 south, 3 west, and six breakpoint bits from index `7*TRK+6*c` joining, in bit order, the end pairs north-east, north-south, north-west, east-south, east-west, south-west; each end's output is the OR of the inputs of every other end reachable through closed breakpoints, directly or through intermediate ends.
- R10: With only the north-south and east-west breakpoints of a compound crossing closed, the two nets stay apart: north and south outputs carry only the south and north inputs, east and west outputs only the west and east inputs.
- R11: With `cfg_en` low, `cfg_din` and clock edges leave the configuration and therefore the routing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, clears the configuration |
| cfg_en | input | 1 | Shift enable for the chain; forces routing outputs to 0 |
| cfg_din | input | 1 | Serial configuration data, most significant bit first |
| cfg_dout | output | 1 | Top bit of the configuration chain |
| n_in | input | TRK | North segment inputs |
| e_in | input | TRK | East segment inputs |
| s_in | input | TRK | South segment inputs |
| w_in | input | TRK | West segment inputs |
| n_out | output | TRK | North segment outputs (decoded multiplexers) |
| e_out | output | TRK | East segment outputs (breakpoints) |
| s_out | output | TRK | South segment outputs (cross-points) |
| w_out | output | TRK | West segment outputs (non-decoded multiplexers) |
| cx_in | input | 4*NCC | Compound crossing end inputs |
| cx_out | output | 4*NCC | Compound crossing end outputs |
| mux_err | output | 1 | More than one enable set in some non-decoded multiplexer |

## Verification
Routing results are combinational: they are due in the same cycle as a change of segment inputs, so the bench drives inputs on the falling edge and samples one nanosecond later, with no clock edge between. A configuration bit lands in the chain at the rising edge after it is presented with `cfg_en` high, so a full load of N bits takes N edges, and the routing checks start only after the falling edge that drops `cfg_en`. Readback through `cfg_dout` is compared one bit per cycle, each bit sampled on the falling edge before the next shift, and the hold-at-zero rule is sampled mid-load while `cfg_en` is high.

// File: rtl/route_switch_box.sv
module route_switch_box #(
  parameter int TRK = 4,
  parameter int NCC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic             cfg_dout,
  input  logic [TRK-1:0]   n_in,
  input  logic [TRK-1:0]   e_in,
  input  logic [TRK-1:0]   s_in,
  input  logic [TRK-1:0]   w_in,
  output logic [TRK-1:0]   n_out,
  output logic [TRK-1:0]   e_out,
  output logic [TRK-1:0]   s_out,
  output logic [TRK-1:0]   w_out,
  input  logic [4*NCC-1:0] cx_in,
  output logic [4*NCC-1:0] cx_out,
  output logic             mux_err
);
  localparam int TW  = 7;
  localparam int CW  = 6;
  localparam int CXB = TRK * TW;
  localparam int LEN = CXB + NCC * CW;

  logic [LEN-1:0] cfg_q;
  logic           live;
  logic [TRK-1:0] dm_v, nd_v, err_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= {cfg_q[LEN-2:0], cfg_din};
  end

  assign cfg_dout = cfg_q[LEN-1];
  assign live     = ~cfg_en;

  for (genvar t = 0; t < TRK; t++) begin : g_trk
    localparam int B = t * TW;
    logic [1:0] code;
    logic [2:0] en;

    assign code = cfg_q[B+3:B+2];
    assign en   = cfg_q[B+6:B+4];

    assign e_out[t] = live & cfg_q[B]   & w_in[t];
    assign s_out[t] = live & cfg_q[B+1] & e_in[t];

    always_comb begin
      case (code)
        2'd1:    dm_v[t] = s_in[t];
        2'd2:    dm_v[t] = w_in[t];
        2'd3:    dm_v[t] = e_in[t];
        default: dm_v[t] = 1'b0;
      endcase
    end

    always_comb begin
      if (en[0])      nd_v[t] = e_in[t];
      else if (en[1]) nd_v[t] = n_in[t];
      else if (en[2]) nd_v[t] = s_in[t];
      else            nd_v[t] = 1'b0;
    end

    assign err_v[t] = (en & (en - 3'd1)) != 3'd0;
    assign n_out[t] = live & dm_v[t];
    assign w_out[t] = live & nd_v[t];
  end

  assign mux_err = live & (|err_v);

  for (genvar c = 0; c < NCC; c++) begin : g_cx
    localparam int CB = CXB + c * CW;
    logic [5:0]      pb;
    logic [3:0][3:0] rch;

    assign pb = cfg_q[CB+5:CB];

    always_comb begin
      rch[0] = {pb[2], pb[1], pb[0], 1'b0};
      rch[1] = {pb[4], pb[3], 1'b0,  pb[0]};
      rch[2] = {pb[5], 1'b0,  pb[3], pb[1]};
      rch[3] = {1'b0,  pb[5], pb[4], pb[2]};
      for (int k = 0; k < 4; k++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            if (rch[i][k] && rch[k][j]) rch[i][j] = 1'b1;
    end

    for (genvar e = 0; e < 4; e++) begin : g_end
      assign cx_out[4*c+e] = live & (|(rch[e] & cx_in[4*c +: 4] & ~(4'b0001 << e)));
    end
  end
endmodule

// File: rtl/route_switch_box_chk.sv
module route_switch_box_chk #(
  parameter int TRK = 4,
  parameter int NCC = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_en,
  input logic                         cfg_din,
  input logic [TRK*7+NCC*6-1:0]       cfg_q,
  input logic [TRK-1:0]               n_out,
  input logic [TRK-1:0]               e_out,
  input logic [TRK-1:0]               s_out,
  input logic [TRK-1:0]               w_out,
  input logic [4*NCC-1:0]             cx_in,
  input logic [4*NCC-1:0]             cx_out,
  input logic                         mux_err
);
  // R3
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (n_out == '0 && e_out == '0 && s_out == '0 && w_out == '0 &&
                cx_out == '0 && !mux_err));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_en) |-> cfg_q[0] == $past(cfg_din));

  // R11
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_en) |-> $stable(cfg_q));

  for (genvar t = 0; t < TRK; t++) begin : g_t
    // R4
    bp_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[7*t] |-> !e_out[t]);
    // R8
    multi_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && $countones(cfg_q[7*t+6:7*t+4]) > 1) |-> mux_err);
  end

  for (genvar c = 0; c < NCC; c++) begin : g_c
    // R10
    two_net_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && cfg_q[TRK*7+6*c +: 6] == 6'b010010) |->
        (cx_out[4*c]   == cx_in[4*c+2] && cx_out[4*c+2] == cx_in[4*c] &&
         cx_out[4*c+1] == cx_in[4*c+3] && cx_out[4*c+3] == cx_in[4*c+1]));
  end
endmodule

bind route_switch_box route_switch_box_chk #(.TRK(TRK), .NCC(NCC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_q(cfg_q),
  .n_out(n_out), .e_out(e_out), .s_out(s_out), .w_out(w_out),
  .cx_in(cx_in), .cx_out(cx_out), .mux_err(mux_err)
);

// File: tb/route_switch_box_test.sv
module route_switch_box_test;
  localparam int TRK = 4;
  localparam int NCC = 2;
  localparam int LEN = TRK * 7 + NCC * 6;

  logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_din = 1'b0;
  logic cfg_dout, mux_err;
  logic [TRK-1:0] n_in = '0, e_in = '0, s_in = '0, w_in = '0;
  logic [TRK-1:0] n_out, e_out, s_out, w_out;
  logic [4*NCC-1:0] cx_in = '0, cx_out;

  int errors = 0, checks = 0;
  logic [LEN-1:0] P = '0;

  always #2 clk = ~clk;

  route_switch_box #(.TRK(TRK), .NCC(NCC)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
    .n_in(n_in), .e_in(e_in), .s_in(s_in), .w_in(w_in),
    .n_out(n_out), .e_out(e_out), .s_out(s_out), .w_out(w_out),
    .cx_in(cx_in), .cx_out(cx_out), .mux_err(mux_err)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [TRK-1:0] xn = '0, xe = '0, xs = '0, xw = '0;
    logic [4*NCC-1:0] xc = '0;
    logic xerr = 1'b0;
    if (!cfg_en) begin
      for (int t = 0; t < TRK; t++) begin
        int b = 7 * t;
        logic [2:0] en;
        xe[t] = P[b] & w_in[t];
        xs[t] = P[b+1] & e_in[t];
        case ({P[b+3], P[b+2]})
          2'd1: xn[t] = s_in[t];
          2'd2: xn[t] = w_in[t];
          2'd3: xn[t] = e_in[t];
          default: xn[t] = 1'b0;
        endcase
        en = {P[b+6], P[b+5], P[b+4]};
        xw[t] = en[0] ? e_in[t] : en[1] ? n_in[t] : en[2] ? s_in[t] : 1'b0;
        if ($countones(en) > 1) xerr = 1'b1;
      end
      for (int c = 0; c < NCC; c++) begin
        int lab[4];
        int pa[6] = '{0, 0, 0, 1, 1, 2};
        int pz[6] = '{1, 2, 3, 2, 3, 3};
        for (int k = 0; k < 4; k++) lab[k] = k;
        for (int r = 0; r < 4; r++)
          for (int p = 0; p < 6; p++)
            if (P[TRK*7 + 6*c + p]) begin
              int m = (lab[pa[p]] < lab[pz[p]]) ? lab[pa[p]] : lab[pz[p]];
              lab[pa[p]] = m;
              lab[pz[p]] = m;
            end
        for (int e = 0; e < 4; e++)
          for (int j = 0; j < 4; j++)
            if (j != e && lab[j] == lab[e]) xc[4*c+e] = xc[4*c+e] | cx_in[4*c+j];
      end
    end
    chk(req, "n_out", 32'(n_out), 32'(xn));
    chk(req, "e_out", 32'(e_out), 32'(xe));
    chk(req, "s_out", 32'(s_out), 32'(xs));
    chk(req, "w_out", 32'(w_out), 32'(xw));
    chk(req, "cx_out", 32'(cx_out), 32'(xc));
    chk(req, "mux_err", 32'(mux_err), 32'(xerr));
  endtask

  task automatic drive(logic [TRK-1:0] n, e, s, w, logic [4*NCC-1:0] cx);
    @(negedge clk);
    n_in = n; e_in = e; s_in = s; w_in = w; cx_in = cx;
    #1;
  endtask

  task automatic load(logic [LEN-1:0] v);
    for (int i = LEN - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1; cfg_din = v[i];
    end
    @(negedge clk);
    cfg_en = 1'b0; cfg_din = 1'b0;
    P = v;
  endtask

  task automatic t_reset();
    drive('1, '1, '1, '1, '1);
    check_all("R1");
  endtask

  task automatic t_shift();
    logic [LEN-1:0] v = 40'hA53C_960F_E1;
    int bad = 0;
    load(v);
    for (int i = LEN - 1; i >= 0; i--) begin
      @(negedge clk);
      if (cfg_dout !== v[i]) bad++;
      cfg_en = 1'b1; cfg_din = 1'b0;
    end
    @(negedge clk);
    cfg_en = 1'b0;
    P = '0;
    chk("R2", "readback mismatches", 32'(bad), 32'd0);
    #1 check_all("R2");
  endtask

  task automatic t_hold();
    logic [LEN-1:0] v = '1;
    drive('1, '1, '1, '1, '1);
    for (int i = LEN - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1; cfg_din = v[i];
      if (i == 3) begin #1 check_all("R3"); end
    end
    @(negedge clk);
    cfg_en = 1'b0;
    P = v;
    #1 check_all("R3");
  endtask

  task automatic t_bp();
    logic [LEN-1:0] v = '0;
    v[0] = 1'b1; v[14] = 1'b1;
    load(v);
    drive('1, '1, '1, 4'b1111, '0);  check_all("R4");
    drive('1, '1, '1, 4'b1010, '0);  check_all("R4");
    drive('0, '0, '0, 4'b0101, '0);  check_all("R4");
  endtask

  task automatic t_xp();
    logic [LEN-1:0] v = '0;
    v[1] = 1'b1; v[22] = 1'b1;
    load(v);
    drive('1, 4'b1111, '0, '1, '0);  check_all("R5");
    drive('0, 4'b0110, '1, '0, '0);  check_all("R5");
  endtask

  task automatic t_dmux();
    logic [LEN-1:0] v = '0;
    {v[3], v[2]}   = 2'd0;
    {v[10], v[9]}  = 2'd1;
    {v[17], v[16]} = 2'd2;
    {v[24], v[23]} = 2'd3;
    load(v);
    drive('0, 4'b1000, 4'b0010, 4'b0100, '0); check_all("R6");
    drive('1, 4'b0111, 4'b1101, 4'b1011, '0); check_all("R6");
    drive('1, '1, '1, '1, '0);                 check_all("R6");
  endtask

  task automatic t_ndm();
    logic [LEN-1:0] v = '0;
    v[11] = 1'b1; v[19] = 1'b1; v[27] = 1'b1;
    load(v);
    drive(4'b0100, 4'b0010, 4'b1000, '0, '0); check_all("R7");
    drive('1, '1, '1, '1, '0);                 check_all("R7");
    drive(4'b1011, 4'b1101, 4'b0111, '1, '0); check_all("R7");
  endtask

  task automatic t_multi();
    logic [LEN-1:0] v = '0;
    v[4] = 1'b1; v[6] = 1'b1;
    v[12] = 1'b1; v[13] = 1'b1;
    load(v);
    drive('1, '0, '1, '0, '0);                 check_all("R8");
    chk("R8", "mux_err raised", 32'(mux_err), 32'd1);
    drive('0, '1, '0, '0, '0);                 check_all("R8");
  endtask

  task automatic t_cx();
    logic [LEN-1:0] v = '0;
    v[28 + 0] = 1'b1;
    v[28 + 3] = 1'b1;
    v[34 + 5] = 1'b1;
    load(v);
    drive('0, '0, '0, '0, 8'b0000_0001); check_all("R9");
    drive('0, '0, '0, '0, 8'b0000_0100); check_all("R9");
    drive('0, '0, '0, '0, 8'b0000_1000); check_all("R9");
    drive('0, '0, '0, '0, 8'b0100_0000); check_all("R9");
    drive('0, '0, '0, '0, 8'b1011_0010); check_all("R9");
  endtask

  task automatic t_iso();
    logic [LEN-1:0] v = '0;
    v[28 + 1] = 1'b1; v[28 + 4] = 1'b1;
    v[34 + 1] = 1'b1; v[34 + 4] = 1'b1;
    load(v);
    for (int k = 0; k < 8; k++) begin
      drive('0, '0, '0, '0, 8'(1 << k));
      check_all("R10");
    end
    drive('0, '0, '0, '0, 8'b0101_1010); check_all("R10");
  endtask

  task automatic t_freeze();
    logic [LEN-1:0] v = 40'h5C_A3B1_7D24;
    load(v);
    drive(4'b1100, 4'b1010, 4'b0110, 4'b0011, 8'hA5);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cfg_din = ~cfg_din;
    end
    #1 check_all("R11");
    chk("R11", "cfg_dout", 32'(cfg_dout), 32'(v[LEN-1]));
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shift();
    t_hold();
    t_bp();
    t_xp();
    t_dmux();
    t_ndm();
    t_multi();
    t_cx();
    t_iso();
    t_freeze();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule